// File: doc/BRIEF.md
# Multi-Game Cartridge Address-Latch Bank Mapper

This block sits between a console CPU and PPU and the memories of a cartridge that holds many small games. A CPU write anywhere in the upper half of the CPU address space loads a control latch from the low CPU address lines. The data bus takes no part and has no input here. The latched word then sets four things. It picks a 16 KiB PRG-ROM page, in either a 16 KiB mode or a 32 KiB mode. It selects the nametable mirroring. It write-protects the 8 KiB of CHR-RAM, which has no banking. It gates the PRG-ROM read enable so that pages past the fitted ROM float the bus and do not alias onto lower pages.

A build-time parameter `SUBMAPPER` selects one of two latch layouts. Layout 0 has eight page bits and puts the protect flag at bit 10. Layout 1 has seven page bits and puts the protect flag at bit 9. `PRG_BANKS` gives the number of fitted 16 KiB pages. The ROM and RAM arrays, the PPU and the nametable RAM are all outside the block.

Top module: `mcart_latch_mapper`

## Requirements
- R1: Synchronous reset clears the latch to zero. After reset the block is in 16 KiB mode on page 0, uses vertical mirroring, and leaves CHR-RAM writable.
- R2: A write cycle, meaning `romsel_n`=0 (CPU at $8000–$FFFF) with `cpu_rw`=0, loads `cpu_addr[10:0]` into the latch on the first clock edge of that cycle. The block has no data-bus input.
- R3: The latch loads only once per write cycle. While the write qualifier stays high, a changed address on later edges is ignored.
- R4: Cycles with `romsel_n`=1 or `cpu_rw`=1 leave the latch unchanged.
- R5: Latch bit 0 selects mirroring. When it is 0 (vertical), `ciram_a10` = `ppu_a10`. When it is 1 (horizontal), `ciram_a10` = `ppu_a11`.
- R6: Latch bit 1 selects the mode. When it is 0 (16 KiB), `prg_addr[14]` = latch bit 2. When it is 1 (32 KiB), `prg_addr[14]` = `cpu_addr[14]`.
- R7: In layout 0, latch bits 9..2 drive `prg_addr[21:14]`, with bit 14 subject to R6.
- R8: In layout 1, latch bits 8..2 drive `prg_addr[20:14]` (bit 14 subject to R6), `prg_addr[21]` is 0, and latch bit 9 is the protect flag.
- R9: `chr_we` = `ppu_we` when the protect flag is 0 and is held at 0 when the flag is 1. The flag is bit 10 in layout 0 and bit 9 in layout 1.
- R10: `prg_rd_en` is 1 only when `romsel_n`=0, `cpu_rw`=1 and the effective page `prg_addr[21:14]` is below `PRG_BANKS`. Otherwise it is 0, including for every page at or past `PRG_BANKS`.
- R11: `prg_addr[13:0]` always equals `cpu_addr[13:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| romsel_n | input | 1 | Active-low select for CPU $8000–$FFFF |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_we | input | 1 | Active-high PPU write strobe to CHR-RAM |
| prg_addr | output | 22 | PRG-ROM address |
| prg_rd_en | output | 1 | PRG-ROM output enable; 0 floats the bus |
| ciram_a10 | output | 1 | Nametable RAM bank select |
| chr_we | output | 1 | Gated CHR-RAM write enable |

## Verification
The latch drives every output combinationally. A wrong latch value therefore shows at the ports in the first cycle after the faulty write. It appears as a wrong page on `prg_addr[21:14]`, as the mirroring source swapping between `ppu_a10` and `ppu_a11`, or as `chr_we` passing or blocking a PPU write that it should not. A compare that is off by one page shows only at the page boundary, when the `PRG_BANKS` edge is crossed. The bench drives pages on both sides of that edge. It runs both layouts side by side so that a protect flag or page bit decoded from the wrong position makes the two instances disagree with their models.

// File: rtl/mcart_pkg.sv
package mcart_pkg;

    localparam int unsigned LATCH_W = 11;
    localparam int unsigned PAGE_W  = 14;
    localparam int unsigned BANK_W  = 8;
    localparam int unsigned PRG_AW  = PAGE_W + BANK_W;

    typedef enum logic {
        MIR_VERT = 1'b0,
        MIR_HORZ = 1'b1
    } mirror_e;

    typedef enum logic {
        MODE_16K = 1'b0,
        MODE_32K = 1'b1
    } prg_mode_e;

    typedef struct packed {
        logic              wprot;
        logic [BANK_W-1:0] bank;
        prg_mode_e         mode;
        mirror_e           mirror;
    } ctrl_t;

    // Effective page: in 32 KiB mode the CPU's A14 replaces the page LSB.
    function automatic logic [BANK_W-1:0] eff_bank(input ctrl_t c, input logic a14);
        logic [BANK_W-1:0] b;
        b = c.bank;
        if (c.mode == MODE_32K) begin
            b[0] = a14;
        end
        return b;
    endfunction

endpackage

// File: rtl/mcart_latch.sv
module mcart_latch
    import mcart_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               romsel_n,
    input  logic               cpu_rw,
    input  logic [LATCH_W-1:0] addr_lo,
    output logic [LATCH_W-1:0] word
);

    logic wr_q;
    logic wr_prev;

    assign wr_q = !romsel_n && !cpu_rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            wr_prev <= 1'b0;
        end else begin
            wr_prev <= wr_q;
            if (wr_q && !wr_prev) begin
                word <= addr_lo;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (word == '0));

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_q && !wr_prev) |=> (word == $past(addr_lo)));

    a_r3_single_update: assert property (@(posedge clk) disable iff (rst)
        (wr_q && wr_prev) |=> $stable(word));

    a_r4_no_capture: assert property (@(posedge clk) disable iff (rst)
        !wr_q |=> $stable(word));

endmodule

// File: rtl/mcart_decode.sv
module mcart_decode
    import mcart_pkg::*;
#(
    parameter int unsigned SUBMAPPER = 0
) (
    input  logic [LATCH_W-1:0] word,
    output ctrl_t              ctrl
);

    generate
        if (SUBMAPPER == 0) begin : g_layout0
            always_comb begin
                ctrl.mirror = mirror_e'(word[0]);
                ctrl.mode   = prg_mode_e'(word[1]);
                ctrl.bank   = word[9:2];
                ctrl.wprot  = word[10];
            end
        end else begin : g_layout1
            logic unused_b10;
            assign unused_b10 = word[10];
            always_comb begin
                ctrl.mirror = mirror_e'(word[0]);
                ctrl.mode   = prg_mode_e'(word[1]);
                ctrl.bank   = {1'b0, word[8:2]};
                ctrl.wprot  = word[9];
            end
        end
    endgenerate

endmodule

// File: rtl/mcart_prg_map.sv
module mcart_prg_map
    import mcart_pkg::*;
#(
    parameter int unsigned PRG_BANKS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [PAGE_W:0]   cpu_a,
    input  logic              romsel_n,
    input  logic              cpu_rw,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_rd_en
);

    localparam logic [BANK_W:0] LIMIT = (BANK_W+1)'(PRG_BANKS);

    logic [BANK_W-1:0] bank;

    always_comb begin
        bank      = eff_bank(ctrl, cpu_a[PAGE_W]);
        prg_addr  = {bank, cpu_a[PAGE_W-1:0]};
        prg_rd_en = !romsel_n && cpu_rw && ({1'b0, bank} < LIMIT);
    end

    a_r10_open_bus: assert property (@(posedge clk) disable iff (rst)
        prg_rd_en |-> (({1'b0, prg_addr[PRG_AW-1:PAGE_W]} < LIMIT) && cpu_rw && !romsel_n));

    a_r6_page_lsb: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_16K) |-> (prg_addr[PAGE_W] == ctrl.bank[0]));

    a_r11_low_pass: assert property (@(posedge clk) disable iff (rst)
        prg_addr[PAGE_W-1:0] == cpu_a[PAGE_W-1:0]);

endmodule

// File: rtl/mcart_ppu_gate.sv
module mcart_ppu_gate
    import mcart_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  ppu_a10,
    input  logic  ppu_a11,
    input  logic  ppu_we,
    output logic  ciram_a10,
    output logic  chr_we
);

    always_comb begin
        ciram_a10 = (ctrl.mirror == MIR_HORZ) ? ppu_a11 : ppu_a10;
        chr_we    = ppu_we && !ctrl.wprot;
    end

    a_r9_protect: assert property (@(posedge clk) disable iff (rst)
        ctrl.wprot |-> !chr_we);

    a_r9_pass: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wprot && ppu_we) |-> chr_we);

endmodule

// File: rtl/mcart_latch_mapper.sv
module mcart_latch_mapper
    import mcart_pkg::*;
#(
    parameter int unsigned SUBMAPPER = 0,
    parameter int unsigned PRG_BANKS = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    input  logic        romsel_n,
    input  logic        ppu_a10,
    input  logic        ppu_a11,
    input  logic        ppu_we,
    output logic [21:0] prg_addr,
    output logic        prg_rd_en,
    output logic        ciram_a10,
    output logic        chr_we
);

    logic [LATCH_W-1:0] word;
    ctrl_t              ctrl;
    logic               unused_a15;

    assign unused_a15 = cpu_addr[15];

    mcart_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .romsel_n (romsel_n),
        .cpu_rw   (cpu_rw),
        .addr_lo  (cpu_addr[LATCH_W-1:0]),
        .word     (word)
    );

    mcart_decode #(.SUBMAPPER(SUBMAPPER)) u_decode (
        .word (word),
        .ctrl (ctrl)
    );

    mcart_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .cpu_a     (cpu_addr[PAGE_W:0]),
        .romsel_n  (romsel_n),
        .cpu_rw    (cpu_rw),
        .prg_addr  (prg_addr),
        .prg_rd_en (prg_rd_en)
    );

    mcart_ppu_gate u_ppu (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ppu_we    (ppu_we),
        .ciram_a10 (ciram_a10),
        .chr_we    (chr_we)
    );

    a_r8_top_zero: assert property (@(posedge clk) disable iff (rst)
        (SUBMAPPER != 0) |-> (prg_addr[21] == 1'b0));

endmodule

// File: tb/mcart_latch_mapper_tb_top.sv
`timescale 1ns/1ps
module mcart_latch_mapper_tb_top;

    localparam int unsigned NB0 = 128;
    localparam int unsigned NB1 = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic        romsel_n = 1'b1;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic        ppu_we = 1'b0;

    logic [21:0] prg0, prg1;
    logic        rd0, rd1, cia0, cia1, chr0, chr1;

    always #2.5 clk = ~clk;

    mcart_latch_mapper #(.SUBMAPPER(0), .PRG_BANKS(NB0)) dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_we(ppu_we),
        .prg_addr(prg0), .prg_rd_en(rd0), .ciram_a10(cia0), .chr_we(chr0)
    );

    mcart_latch_mapper #(.SUBMAPPER(1), .PRG_BANKS(NB1)) dut1_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_we(ppu_we),
        .prg_addr(prg1), .prg_rd_en(rd1), .ciram_a10(cia1), .chr_we(chr1)
    );

    typedef struct {
        logic [21:0] prg0, prg1;
        logic        rd0, rd1, cia, chr0, chr1;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    logic [15:0] lat = 16'h0000;
    logic prev_wq = 1'b0;
    bit done = 1'b0;

    function automatic logic [7:0] m_bank(int sm, logic [15:0] l, logic [15:0] a);
        logic [7:0] b;
        b = (sm == 0) ? l[9:2] : {1'b0, l[8:2]};
        if (l[1]) b[0] = a[14];
        return b;
    endfunction

    task automatic chk(string tag, string what, logic [21:0] act, logic [21:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(logic rs_n, logic rw, logic [15:0] a,
                        logic a10, logic a11, logic we, string tag);
        item_t it;
        logic wq;
        @(negedge clk);
        romsel_n = rs_n; cpu_rw = rw; cpu_addr = a;
        ppu_a10 = a10; ppu_a11 = a11; ppu_we = we;
        wq = !rs_n && !rw;
        if (wq && !prev_wq) lat = a;
        prev_wq = wq;
        @(posedge clk);
        #1;
        it.prg0 = {m_bank(0, lat, a), a[13:0]};
        it.prg1 = {m_bank(1, lat, a), a[13:0]};
        it.rd0  = !rs_n && rw && (m_bank(0, lat, a) < 8'(NB0));
        it.rd1  = !rs_n && rw && (m_bank(1, lat, a) < 8'(NB1));
        it.cia  = lat[0] ? a11 : a10;
        it.chr0 = we && !lat[10];
        it.chr1 = we && !lat[9];
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic wr(logic [15:0] a, string tag);
        step(1'b0, 1'b0, a, 1'b0, 1'b0, 1'b0, tag);
        step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(logic [15:0] a, logic a10, logic a11, logic we, string tag);
        step(1'b0, 1'b1, a, a10, a11, we, tag);
    endtask

    // Monitor: pops expectations and compares them with the outputs.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, "prg_addr(sm0)", prg0, it.prg0);
                chk(it.tag, "prg_addr(sm1)", prg1, it.prg1);
                chk(it.tag, "prg_rd_en(sm0)", 22'(rd0), 22'(it.rd0));
                chk(it.tag, "prg_rd_en(sm1)", 22'(rd1), 22'(it.rd1));
                chk(it.tag, "ciram_a10(sm0)", 22'(cia0), 22'(it.cia));
                chk(it.tag, "ciram_a10(sm1)", 22'(cia1), 22'(it.cia));
                chk(it.tag, "chr_we(sm0)", 22'(chr0), 22'(it.chr0));
                chk(it.tag, "chr_we(sm1)", 22'(chr1), 22'(it.chr1));
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(16'h8123, 1'b1, 1'b0, 1'b1, "R1");
        rd(16'hC123, 1'b0, 1'b1, 1'b1, "R1");

        // R5: mirroring source
        rd(16'h8000, 1'b1, 1'b0, 1'b0, "R5");
        wr(16'h8001, "R2");
        rd(16'h8000, 1'b1, 1'b0, 1'b0, "R5");
        rd(16'h8000, 1'b0, 1'b1, 1'b0, "R5");

        // R6/R7/R8: 16 KiB mode, page 0x55 (sm1 sees 0x55)
        wr(16'h8000 | (16'h55 << 2), "R2");
        rd(16'h8ABC, 1'b0, 1'b0, 1'b0, "R6");
        rd(16'hC1FF, 1'b0, 1'b0, 1'b0, "R7");
        // 32 KiB mode
        wr(16'h8002 | (16'h2A << 2), "R6");
        rd(16'h8000, 1'b0, 1'b0, 1'b0, "R6");
        rd(16'hFFFF, 1'b0, 1'b0, 1'b0, "R11");

        // R10/R8: page 200 -> sm0 open bus, sm1 page 72 >= 64 open bus, A21 zero
        wr(16'h8000 | (16'd200 << 2), "R8");
        rd(16'h8010, 1'b0, 1'b0, 1'b0, "R10");
        wr(16'h8000 | (16'd127 << 2), "R10");
        rd(16'h8010, 1'b0, 1'b0, 1'b0, "R10");
        wr(16'h8000 | (16'd63 << 2), "R10");
        rd(16'hC010, 1'b0, 1'b0, 1'b0, "R10");
        wr(16'h8000 | (16'd64 << 2), "R10");
        rd(16'hC010, 1'b0, 1'b0, 1'b0, "R10");
        // write cycle is never a read
        step(1'b0, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, "R10");

        // R9: protect flag positions
        wr(16'h8400, "R9");
        rd(16'h8000, 1'b0, 1'b0, 1'b1, "R9");
        wr(16'h8200, "R9");
        rd(16'h8000, 1'b0, 1'b0, 1'b1, "R9");
        wr(16'h8600, "R9");
        rd(16'h8000, 1'b0, 1'b0, 1'b1, "R9");
        wr(16'h8000, "R9");
        rd(16'h8000, 1'b0, 1'b0, 1'b1, "R9");

        // R4: non-qualified cycles leave the latch alone
        step(1'b1, 1'b0, 16'h07FF, 1'b1, 1'b0, 1'b1, "R4");
        rd(16'h8000, 1'b1, 1'b0, 1'b1, "R4");
        rd(16'h87FF, 1'b1, 1'b0, 1'b1, "R4");
        rd(16'h8000, 1'b1, 1'b0, 1'b1, "R4");

        // R3: held write loads only once
        step(1'b0, 1'b0, 16'h8001 | (16'h11 << 2), 1'b0, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b0, 16'h8602, 1'b0, 1'b1, 1'b1, "R3");
        step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, "R3");
        rd(16'h8123, 1'b0, 1'b1, 1'b1, "R3");

        // R11: low bits pass through
        rd(16'hA5A5, 1'b0, 1'b0, 1'b0, "R11");
        rd(16'h9234, 1'b0, 1'b0, 1'b0, "R11");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule